// File: doc/BRIEF.md
# Binary Extension Field Power Sequencer and Multiplier

This block performs arithmetic in a binary extension field GF(2^M) built on a primitive polynomial. It holds two independent functions. A clocked sequencer starts at the element 1 and, on each enabled clock, multiplies its current element by the primitive element x. It walks through all 2^M-1 non-zero elements of the field, reports the exponent of the element it holds, and raises a flag on the step that brings it back to 1. A purely combinational multiplier returns the field product of two operands, reduced by the polynomial.

Field elements are M-bit vectors whose bit k is the coefficient of x^k. Field addition is bitwise XOR. Multiplication by x is a one-place left shift; when the bit leaving the top is 1, the low M coefficients of the polynomial are XORed into the result. The general multiplier chains M such shift stages and adds the first operand wherever the second operand has a set bit. The defaults are M = 4 and the polynomial x^4+x+1 (`POLY` = 5'h13). Other fields are chosen through the parameters, for example x^3+x+1 for M = 3 or x^8+x^4+x^3+x^2+1 for M = 8.

Typical uses are generating the power table that an error-correcting code needs, and computing products inside syndrome or encoder datapaths.

Top module: `gf_pow_mul`

## Requirements
- R1: After reset, and while reset is held low, `pow_o` = 1, `exp_o` = 0 and `wrap_o` = 0.
- R2: On a rising edge with `step_i` = 1 and `start_i` = 0, `pow_o` becomes its previous value times x. That is a left shift by one with bit 0 = 0, XORed with the low M bits of `POLY` when the old bit M-1 was 1. `exp_o` increments. For the default field, the values after 4, 5, 7 and 14 steps are 4'b0011, 4'b0110, 4'b1011 and 4'b1001.
- R3: On the step taken while `exp_o` = 2^M-2, `pow_o` returns to 1 and `exp_o` returns to 0. `wrap_o` is 1 for exactly the one cycle that follows that step and 0 after every other step.
- R4: Over 2^M-1 consecutive steps from 1, `pow_o` is never 0 and no value repeats.
- R5: On an edge with `step_i` = 0 and `start_i` = 0, `pow_o` and `exp_o` keep their values and `wrap_o` becomes 0.
- R6: On an edge with `start_i` = 1, the sequencer goes to `pow_o` = 1, `exp_o` = 0 and `wrap_o` = 0, whatever `step_i` is.
- R7: `p_o` is the product of `a_i` and `b_i` as polynomials over GF(2), reduced modulo `POLY`. It is combinational, so it is valid in the same cycle as its operands, and swapping the operands gives the same result.
- R8: If either operand is 0 then `p_o` = 0. If `b_i` = 1 then `p_o` = `a_i`, and if `a_i` = 1 then `p_o` = `b_i`.
- R9: For all exponents i and j in 0..2^M-2, the product alpha^i * alpha^j equals alpha^((i+j) mod (2^M-1)), where alpha = x.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Restart the sequence at 1 (takes priority over step_i) |
| step_i | input | 1 | Advance the sequencer by one power |
| pow_o | output | M | Current power of the primitive element |
| exp_o | output | M | Exponent of pow_o, 0..2^M-2 |
| wrap_o | output | 1 | One-cycle flag after the step that returns to 1 |
| a_i | input | M | Multiplier operand a |
| b_i | input | M | Multiplier operand b |
| p_o | output | M | Field product of a_i and b_i |

## Verification
The sequencer outputs are registered, so each is due one rising edge after the control inputs that cause it. The bench drives `start_i` and `step_i` on the falling edge and reads `pow_o`, `exp_o` and `wrap_o` on the next falling edge, half a period after the update. The multiplier has no register, so the bench applies each operand pair and samples `p_o` one time unit later within the same cycle. Every product is compared against a model that forms the full carry-less product and then reduces it from the top bit downward. This is a different method from the Horner chain in the design. The bench sweeps all operand pairs of the default field, and every power pair for the exponent rule.

// File: rtl/gf_xtime_unit.sv
module gf_xtime_unit #(
  parameter int unsigned   M   = 4,
  parameter logic [M-1:0]  RED = 4'h3
) (
  input  logic [M-1:0] v_i,
  output logic [M-1:0] y_o
);
  // carry out of the top coefficient decides whether to fold the polynomial
  logic carry_out;

  function automatic logic [M-1:0] mul_by_x(input logic [M-1:0] v);
    logic [M-1:0] sh;
    sh = {v[M-2:0], 1'b0};
    return v[M-1] ? (sh ^ RED) : sh;
  endfunction

  assign carry_out = v_i[M-1];
  assign y_o       = mul_by_x(v_i);

  // R2: bit 0 of the result carries the polynomial's constant term only after a fold
  always_comb begin
    if (!carry_out) r2_lsb_clear_chk: assert (y_o[0] == 1'b0);
  end
endmodule

// File: rtl/gf_mul.sv
module gf_mul #(
  parameter int unsigned   M   = 4,
  parameter logic [M-1:0]  RED = 4'h3
) (
  input  logic [M-1:0] a_i,
  input  logic [M-1:0] b_i,
  output logic [M-1:0] p_o
);
  // Horner chain: acc(k+1) = acc(k)*x + b[M-1-k]*a
  logic [M-1:0] acc     [0:M];
  logic [M-1:0] shifted [0:M-1];

  assign acc[0] = '0;

  for (genvar g = 0; g < M; g++) begin : g_stage
    gf_xtime_unit #(.M(M), .RED(RED)) u_xt (
      .v_i (acc[g]),
      .y_o (shifted[g])
    );
    assign acc[g+1] = shifted[g] ^ (b_i[M-1-g] ? a_i : '0);
  end

  assign p_o = acc[M];
endmodule

// File: rtl/gf_pow_seq.sv
module gf_pow_seq #(
  parameter int unsigned   M   = 4,
  parameter logic [M-1:0]  RED = 4'h3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         step_i,
  output logic [M-1:0] pow_o,
  output logic [M-1:0] exp_o,
  output logic         wrap_o
);
  localparam logic [M-1:0] ONE  = M'(1);
  localparam logic [M-1:0] LAST = M'((1 << M) - 2);

  logic [M-1:0] pow_q, exp_q, pow_next;
  logic         wrap_q;
  logic         adv;        // a step is taken this cycle
  logic         at_last;    // exponent sits at the top of the period

  gf_xtime_unit #(.M(M), .RED(RED)) u_step (
    .v_i (pow_q),
    .y_o (pow_next)
  );

  assign adv     = step_i && !start_i;
  assign at_last = (exp_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pow_q  <= ONE;
      exp_q  <= '0;
      wrap_q <= 1'b0;
    end else if (start_i) begin
      pow_q  <= ONE;
      exp_q  <= '0;
      wrap_q <= 1'b0;
    end else if (adv) begin
      pow_q  <= pow_next;
      exp_q  <= at_last ? '0 : exp_q + ONE;
      wrap_q <= at_last;
    end else begin
      wrap_q <= 1'b0;
    end
  end

  assign pow_o  = pow_q;
  assign exp_o  = exp_q;
  assign wrap_o = wrap_q;

  // R4
  // pow_never_zero_chk
  pow_never_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pow_q != '0);

  // R2
  step_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !at_last) |=> (exp_q == $past(exp_q) + ONE) && (pow_q != $past(pow_q)));

  // R3
  wrap_lands_on_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_q |-> (pow_q == ONE) && (exp_q == '0));

  // R3
  wrap_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_q |=> !wrap_q);

  // R3
  exp_zero_means_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_q == '0) |-> (pow_q == ONE));

  // R5
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !start_i) |=> $stable(pow_q) && $stable(exp_q) && !wrap_q);

  // R6
  start_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (pow_q == ONE) && (exp_q == '0) && !wrap_q);
endmodule

// File: rtl/gf_pow_mul.sv
module gf_pow_mul #(
  parameter int unsigned M    = 4,
  parameter logic [M:0]  POLY = 5'h13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         step_i,
  output logic [M-1:0] pow_o,
  output logic [M-1:0] exp_o,
  output logic         wrap_o,
  input  logic [M-1:0] a_i,
  input  logic [M-1:0] b_i,
  output logic [M-1:0] p_o
);
  localparam logic [M-1:0] RED = POLY[M-1:0];
  localparam logic [M-1:0] ONE = M'(1);

  gf_pow_seq #(.M(M), .RED(RED)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .step_i  (step_i),
    .pow_o   (pow_o),
    .exp_o   (exp_o),
    .wrap_o  (wrap_o)
  );

  gf_mul #(.M(M), .RED(RED)) u_mul (
    .a_i (a_i),
    .b_i (b_i),
    .p_o (p_o)
  );

  // R8
  zero_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((a_i == '0) || (b_i == '0)) |-> (p_o == '0));

  // R8
  unit_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((b_i == ONE) |-> (p_o == a_i)) and ((a_i == ONE) |-> (p_o == b_i)));

  // R7
  nonzero_product_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((a_i != '0) && (b_i != '0)) |-> (p_o != '0));
endmodule

// File: tb/tb_gf_pow_mul.sv
module tb_gf_pow_mul;
  localparam int       CLK_PERIOD = 10;
  localparam int       M          = 4;
  localparam int       NZ         = (1 << M) - 1;
  localparam logic [M:0] POLY     = 5'h13;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0, step_i = 1'b0;
  logic [M-1:0] pow_o, exp_o, a_i = '0, b_i = '0, p_o;
  logic         wrap_o;

  int compared = 0;
  int mismatched = 0;
  logic [M-1:0] alpha [0:NZ-1];

  gf_pow_mul #(.M(M), .POLY(POLY)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .step_i(step_i),
    .pow_o(pow_o), .exp_o(exp_o), .wrap_o(wrap_o),
    .a_i(a_i), .b_i(b_i), .p_o(p_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // carry-less product, then reduce from the top coefficient downward
  function automatic logic [M-1:0] ref_mul(input logic [M-1:0] a, input logic [M-1:0] b);
    logic [2*M-1:0] prod = '0;
    for (int i = 0; i < M; i++)
      if (b[i]) prod = prod ^ ((2*M)'(a) << i);
    for (int k = 2*M-2; k >= M; k--)
      if (prod[k]) prod = prod ^ ((2*M)'(POLY) << (k - M));
    return prod[M-1:0];
  endfunction

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [NZ:0] seen;
    alpha[0] = 1;
    for (int i = 1; i < NZ; i++) alpha[i] = ref_mul(alpha[i-1], 2);

    // R1: reset state
    @(negedge clk);
    check("R1 pow", int'(pow_o), 1);
    check("R1 exp", int'(exp_o), 0);
    check("R1 wrap", int'(wrap_o), 0);
    rst_n = 1'b1;
    cycle();
    check("R5 idle after reset", int'(pow_o), 1);

    // R2, R3, R4: walk one full period
    seen = '0;
    seen[1] = 1'b1;
    step_i = 1'b1;
    for (int k = 1; k <= NZ; k++) begin
      cycle();
      check("R2 pow", int'(pow_o), int'(alpha[k % NZ]));
      check("R2 exp", int'(exp_o), k % NZ);
      check("R3 wrap", int'(wrap_o), (k == NZ) ? 1 : 0);
      if (k < NZ) begin
        check("R4 nonzero", int'(pow_o != '0), 1);
        check("R4 unique", int'(seen[pow_o]), 0);
        seen[pow_o] = 1'b1;
      end
      if (k == 4)  check("R2 alpha4", int'(pow_o), 4'b0011);
      if (k == 5)  check("R2 alpha5", int'(pow_o), 4'b0110);
      if (k == 7)  check("R2 alpha7", int'(pow_o), 4'b1011);
      if (k == 14) check("R2 alpha14", int'(pow_o), 4'b1001);
    end
    check("R4 all visited", int'($countones(seen)), NZ);

    // R5: hold with step low; wrap drops
    cycle();
    check("R2 after wrap", int'(pow_o), int'(alpha[1]));
    check("R3 wrap low", int'(wrap_o), 0);
    step_i = 1'b0;
    for (int k = 0; k < 3; k++) begin
      cycle();
      check("R5 pow hold", int'(pow_o), int'(alpha[1]));
      check("R5 exp hold", int'(exp_o), 1);
      check("R5 wrap", int'(wrap_o), 0);
    end

    // R6: start wins over step
    step_i = 1'b1;
    cycle(); cycle();
    check("R2 resume", int'(exp_o), 3);
    start_i = 1'b1;
    cycle();
    check("R6 pow", int'(pow_o), 1);
    check("R6 exp", int'(exp_o), 0);
    check("R6 wrap", int'(wrap_o), 0);
    start_i = 1'b0;
    step_i = 1'b0;

    // R7, R8: exhaustive operand sweep
    for (int a = 0; a <= NZ; a++) begin
      for (int b = 0; b <= NZ; b++) begin
        logic [M-1:0] p_ab;
        a_i = M'(a); b_i = M'(b);
        #1;
        p_ab = p_o;
        check("R7 product", int'(p_ab), int'(ref_mul(M'(a), M'(b))));
        if (a == 0 || b == 0) check("R8 zero", int'(p_ab), 0);
        if (b == 1) check("R8 unit b", int'(p_ab), a);
        if (a == 1) check("R8 unit a", int'(p_ab), b);
        a_i = M'(b); b_i = M'(a);
        #1;
        check("R7 commute", int'(p_o), int'(p_ab));
      end
    end

    // R9: exponent addition
    for (int i = 0; i < NZ; i++) begin
      for (int j = 0; j < NZ; j++) begin
        a_i = alpha[i]; b_i = alpha[j];
        #1;
        check("R9 exponent sum", int'(p_o), int'(alpha[(i + j) % NZ]));
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule